// File: doc/BRIEF.md
# Scan Velocity Modulation Drive Pipeline

This block turns a stream of 8-bit RGB pixels, one per clock, into an 8-bit drive code for the scan-velocity-modulation DAC. The code is centred at 128. Each pixel is reduced to a luma value, and a difference filter measures how far that luma has moved over a programmable span of earlier pixels. The difference is then shaped in three steps: small values are cored away as noise, the rest is scaled by a fixed-point gain, and the result is clipped to a symmetric limit. A short delay line with half-clock resolution aligns the drive code with the rest of the display path.

Two parameter sets, A and B, each hold a filter span and a gain. A per-pixel overlay-select input chooses between them. This is the same signal that chooses between video RGB and overlay RGB elsewhere. The selection follows each pixel through the pipeline, so the span and the gain for a pixel always come from the same set. The coring threshold, the limit and the delay code are shared by both sets. All parameters are plain input ports.

Top module: `svm_pipe`

## Requirements
- R1: While reset is asserted and after its release with no pixel activity, `drive_o` is 128.
- R2: Luma is Y = (R + 2G + B) >> 2. The filter output for pixel p is Y[p] − Y[p−N], where a pixel before reset counts as 0. The span code is clamped to an effective N: a span code of 0 acts as N = 1, and a span code of 7 acts as N = 6.
- R3: When `osd_sel_i` is 1 for a pixel, the difference for that pixel uses `span_b_i` and its scaling uses `gain_b_i`. When `osd_sel_i` is 0, they use `span_a_i` and `gain_a_i`.
- R4: If the magnitude of the difference is at or below `core_thr_i`, the shaped code is 128. Otherwise `core_thr_i` is subtracted from the magnitude and the sign is kept.
- R5: The cored magnitude is multiplied by the unsigned gain, which has 5 fraction bits, and is truncated toward zero. A positive difference gives a code of 128 or above, and a negative difference gives a code of 128 or below.
- R6: The scaled magnitude is clipped to L = min(`limit_i`, 127). The shaped code is 128 + m for a positive difference and 128 − m for a negative one, so it never reaches 0.
- R7: `dly_code_i` is a signed 4-bit value c in half-clock units, and the total delay in halves is h = 7 + c. With k = h >> 1, `drive_o` after clock edge E is S[E−3−k] when h is even. When h is odd it is (S[E−3−k] + S[E−4−k] + 1) >> 1. Here S[p] is the shaped code of the pixel captured at edge p, and S of a pixel before reset is 128.
- R8: The delay code −8, which lies outside the range −7..+7, saturates and behaves exactly like −7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| red_i | input | 8 | Red component of the current pixel |
| grn_i | input | 8 | Green component of the current pixel |
| blu_i | input | 8 | Blue component of the current pixel |
| osd_sel_i | input | 1 | Per-pixel choice of parameter set B (1) or A (0) |
| span_a_i | input | 3 | Difference span code of set A |
| span_b_i | input | 3 | Difference span code of set B |
| gain_a_i | input | 8 | Gain of set A, unsigned, 3 integer and 5 fraction bits |
| gain_b_i | input | 8 | Gain of set B, unsigned, 3 integer and 5 fraction bits |
| core_thr_i | input | 8 | Coring threshold on the difference magnitude |
| limit_i | input | 8 | Symmetric clip level around 128 |
| dly_code_i | input | 4 | Signed output delay in half-clock steps |
| drive_o | output | 8 | Drive code for the DAC, centred at 128 |

## Verification
The shaping assertions compare the registered difference with the coring threshold and the code produced one clock later. They therefore rely on `core_thr_i` and the gain ports being known values at the clock edge where a pixel is shaped. The delay assertions rely in the same way on `dly_code_i` being known at that edge. Each scenario sets all parameter ports before reset is applied and leaves them untouched while pixels stream. Only the pixel data and `osd_sel_i` change from one pixel to the next, so expected codes can be computed from whole-scenario constants.

// File: rtl/svm_pkg.sv
package svm_pkg;

    localparam int PIX_W     = 8;
    localparam int SPAN_W    = 3;
    localparam int MAX_SPAN  = 6;
    localparam int GAIN_W    = 8;
    localparam int GAIN_FRAC = 5;
    localparam int DLY_W     = 4;

    // Map a raw span code onto the legal range 1..max_span.
    function automatic logic [SPAN_W-1:0] clamp_span(input logic [SPAN_W-1:0] raw,
                                                     input int max_span);
        logic [SPAN_W-1:0] res;
        if (raw == '0)
            res = SPAN_W'(1);
        else if (int'(raw) > max_span)
            res = SPAN_W'(max_span);
        else
            res = raw;
        return res;
    endfunction

endpackage

// File: rtl/svm_diff.sv
module svm_diff
    import svm_pkg::*;
#(
    parameter int P_PIX_W    = PIX_W,
    parameter int P_SPAN_W   = SPAN_W,
    parameter int P_MAX_SPAN = MAX_SPAN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [P_PIX_W-1:0]        red_i,
    input  logic [P_PIX_W-1:0]        grn_i,
    input  logic [P_PIX_W-1:0]        blu_i,
    input  logic                      sel_i,
    input  logic [P_SPAN_W-1:0]       span_a_i,
    input  logic [P_SPAN_W-1:0]       span_b_i,
    output logic signed [P_PIX_W:0]   diff_o,
    output logic                      sel_o
);
    localparam int DIFF_W = P_PIX_W + 1;
    localparam int SUM_W  = P_PIX_W + 2;

    typedef struct packed {
        logic [P_PIX_W-1:0]                    luma;
        logic                                  sel_y;
        logic [P_MAX_SPAN-1:0][P_PIX_W-1:0]    hist;
        logic signed [DIFF_W-1:0]              diff;
        logic                                  sel_d;
    } diff_st_t;

    diff_st_t st_d, st_q;
    logic [SUM_W-1:0]     wsum;
    logic [P_SPAN_W-1:0]  span_eff;
    logic [P_PIX_W-1:0]   older;

    always_comb begin
        st_d = st_q;
        wsum = SUM_W'(red_i) + {1'b0, grn_i, 1'b0} + SUM_W'(blu_i);
        st_d.luma  = P_PIX_W'(wsum >> 2);
        st_d.sel_y = sel_i;

        st_d.hist[0] = st_q.luma;
        for (int i = 1; i < P_MAX_SPAN; i++)
            st_d.hist[i] = st_q.hist[i-1];

        span_eff = st_q.sel_y ? clamp_span(span_b_i, P_MAX_SPAN)
                              : clamp_span(span_a_i, P_MAX_SPAN);
        older = '0;
        for (int i = 0; i < P_MAX_SPAN; i++)
            if (P_SPAN_W'(i + 1) == span_eff)
                older = st_q.hist[i];

        st_d.diff  = $signed({1'b0, st_q.luma}) - $signed({1'b0, older});
        st_d.sel_d = st_q.sel_y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign diff_o = st_q.diff;
    assign sel_o  = st_q.sel_d;

    // R2: a span of one compares neighbours, so two equal successive lumas give zero
    assert_flat_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.luma == st_q.hist[0] && span_eff == P_SPAN_W'(1)) |=> (diff_o == '0));

endmodule

// File: rtl/svm_shape.sv
module svm_shape
    import svm_pkg::*;
#(
    parameter int P_PIX_W     = PIX_W,
    parameter int P_GAIN_W    = GAIN_W,
    parameter int P_GAIN_FRAC = GAIN_FRAC
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [P_PIX_W:0]   diff_i,
    input  logic                      sel_i,
    input  logic [P_GAIN_W-1:0]       gain_a_i,
    input  logic [P_GAIN_W-1:0]       gain_b_i,
    input  logic [P_PIX_W-1:0]        thr_i,
    input  logic [P_PIX_W-1:0]        lim_i,
    output logic [P_PIX_W-1:0]        code_o
);
    localparam int DIFF_W = P_PIX_W + 1;
    localparam int MAG_W  = DIFF_W;
    localparam int PROD_W = MAG_W + P_GAIN_W;
    localparam logic [P_PIX_W-1:0] MID_CODE = {1'b1, {(P_PIX_W-1){1'b0}}};
    localparam logic [P_PIX_W-1:0] LIM_MAX  = {1'b0, {(P_PIX_W-1){1'b1}}};

    typedef struct packed {
        logic [P_PIX_W-1:0] code;
    } shape_st_t;

    shape_st_t st_d, st_q;
    logic                 neg;
    logic [MAG_W-1:0]     mag, thr_ext, cored;
    logic [P_GAIN_W-1:0]  gain;
    logic [PROD_W-1:0]    scaled;
    logic [P_PIX_W-1:0]   lim_eff, clip;

    always_comb begin
        neg     = diff_i[DIFF_W-1];
        mag     = neg ? MAG_W'(-diff_i) : MAG_W'(diff_i);
        thr_ext = MAG_W'(thr_i);
        cored   = (mag > thr_ext) ? (mag - thr_ext) : '0;
        gain    = sel_i ? gain_b_i : gain_a_i;
        scaled  = (PROD_W'(cored) * PROD_W'(gain)) >> P_GAIN_FRAC;
        lim_eff = (lim_i > LIM_MAX) ? LIM_MAX : lim_i;
        clip    = (scaled > PROD_W'(lim_eff)) ? lim_eff : P_PIX_W'(scaled);
        st_d.code = neg ? (MID_CODE - clip) : (MID_CODE + clip);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= MID_CODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;

    // R4: differences inside the coring band produce the mid code
    assert_core_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_i <= $signed({1'b0, thr_i}) && diff_i >= -$signed({1'b0, thr_i}))
        |=> (code_o == MID_CODE));

    // R5: the sign of the difference decides the side of the mid code
    assert_sign_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_i > 0) |=> (code_o >= MID_CODE));
    assert_sign_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_i < 0) |=> (code_o <= MID_CODE));

endmodule

// File: rtl/svm_delay.sv
module svm_delay
    import svm_pkg::*;
#(
    parameter int P_PIX_W = PIX_W,
    parameter int P_DLY_W = DLY_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [P_PIX_W-1:0]          in_i,
    input  logic signed [P_DLY_W-1:0]   dly_i,
    output logic [P_PIX_W-1:0]          out_o
);
    localparam int CODE_MAX = 2 ** (P_DLY_W - 1) - 1;
    localparam int LINE_LEN = CODE_MAX;
    localparam int IDX_W    = $clog2(LINE_LEN + 1);
    localparam int H_W      = IDX_W + 1;
    localparam logic [P_PIX_W-1:0] MID_CODE = {1'b1, {(P_PIX_W-1){1'b0}}};
    localparam logic [P_DLY_W-1:0] CODE_LOW  = {1'b1, {(P_DLY_W-2){1'b0}}, 1'b1};
    localparam logic [P_DLY_W-1:0] CODE_OVER = {1'b1, {(P_DLY_W-1){1'b0}}};

    typedef struct packed {
        logic [LINE_LEN-1:0][P_PIX_W-1:0] taps;
        logic [P_PIX_W-1:0]               out;
    } dly_st_t;

    dly_st_t st_d, st_q;
    logic [LINE_LEN:0][P_PIX_W-1:0] win;
    logic signed [P_DLY_W-1:0]      csat;
    logic [H_W-1:0]                 halves;
    logic [IDX_W-1:0]               k, k_nxt;
    logic [P_PIX_W-1:0]             near, far;
    logic [P_PIX_W:0]               pair;

    always_comb begin
        st_d = st_q;
        st_d.taps[0] = in_i;
        for (int j = 1; j < LINE_LEN; j++)
            st_d.taps[j] = st_q.taps[j-1];

        win[0] = in_i;
        for (int j = 1; j <= LINE_LEN; j++)
            win[j] = st_q.taps[j-1];

        csat   = (dly_i == $signed(CODE_OVER)) ? $signed(CODE_LOW) : dly_i;
        halves = H_W'(CODE_MAX) + H_W'(csat);
        k      = halves[H_W-1:1];
        k_nxt  = (k == IDX_W'(LINE_LEN)) ? k : (k + 1'b1);

        near = win[0];
        far  = win[0];
        for (int j = 0; j <= LINE_LEN; j++) begin
            if (IDX_W'(j) == k)     near = win[j];
            if (IDX_W'(j) == k_nxt) far  = win[j];
        end

        pair = ({1'b0, near} + {1'b0, far} + 1'b1) >> 1;
        st_d.out = halves[0] ? P_PIX_W'(pair) : near;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.taps <= {LINE_LEN{MID_CODE}};
            st_q.out  <= MID_CODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    // R7: the shortest delay forwards the incoming code after one register
    assert_min_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_i == $signed(CODE_LOW)) |=> (out_o == $past(in_i)));

    // R8: the out-of-range code acts as the shortest delay
    assert_code_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_i == $signed(CODE_OVER)) |=> (out_o == $past(in_i)));

endmodule

// File: rtl/svm_pipe.sv
module svm_pipe
    import svm_pkg::*;
#(
    parameter int P_PIX_W     = PIX_W,
    parameter int P_SPAN_W    = SPAN_W,
    parameter int P_MAX_SPAN  = MAX_SPAN,
    parameter int P_GAIN_W    = GAIN_W,
    parameter int P_GAIN_FRAC = GAIN_FRAC,
    parameter int P_DLY_W     = DLY_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [P_PIX_W-1:0]         red_i,
    input  logic [P_PIX_W-1:0]         grn_i,
    input  logic [P_PIX_W-1:0]         blu_i,
    input  logic                       osd_sel_i,
    input  logic [P_SPAN_W-1:0]        span_a_i,
    input  logic [P_SPAN_W-1:0]        span_b_i,
    input  logic [P_GAIN_W-1:0]        gain_a_i,
    input  logic [P_GAIN_W-1:0]        gain_b_i,
    input  logic [P_PIX_W-1:0]         core_thr_i,
    input  logic [P_PIX_W-1:0]         limit_i,
    input  logic signed [P_DLY_W-1:0]  dly_code_i,
    output logic [P_PIX_W-1:0]         drive_o
);
    logic signed [P_PIX_W:0] diff_w;
    logic                    sel_w;
    logic [P_PIX_W-1:0]      shaped_w;

    svm_diff #(
        .P_PIX_W(P_PIX_W), .P_SPAN_W(P_SPAN_W), .P_MAX_SPAN(P_MAX_SPAN)
    ) diff_i (
        .clk(clk), .rst_n(rst_n),
        .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
        .sel_i(osd_sel_i), .span_a_i(span_a_i), .span_b_i(span_b_i),
        .diff_o(diff_w), .sel_o(sel_w)
    );

    svm_shape #(
        .P_PIX_W(P_PIX_W), .P_GAIN_W(P_GAIN_W), .P_GAIN_FRAC(P_GAIN_FRAC)
    ) shape_i (
        .clk(clk), .rst_n(rst_n),
        .diff_i(diff_w), .sel_i(sel_w),
        .gain_a_i(gain_a_i), .gain_b_i(gain_b_i),
        .thr_i(core_thr_i), .lim_i(limit_i),
        .code_o(shaped_w)
    );

    svm_delay #(
        .P_PIX_W(P_PIX_W), .P_DLY_W(P_DLY_W)
    ) delay_i (
        .clk(clk), .rst_n(rst_n),
        .in_i(shaped_w), .dly_i(dly_code_i),
        .out_o(drive_o)
    );

    // R6: the clipped code stays strictly above zero
    assert_code_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o != '0);

    // R1: the cycle after reset the output sits at the mid code
    assert_reset_mid_R1: assert property (@(posedge clk)
        !rst_n |=> (drive_o == {1'b1, {(P_PIX_W-1){1'b0}}}));

endmodule

// File: tb/svm_pipe_tb_top.sv
module svm_pipe_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPIX = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] red_i = '0, grn_i = '0, blu_i = '0;
    logic osd_sel_i = 1'b0;
    logic [2:0] span_a_i = 3'd1, span_b_i = 3'd1;
    logic [7:0] gain_a_i = 8'd32, gain_b_i = 8'd32;
    logic [7:0] core_thr_i = '0, limit_i = 8'd127;
    logic signed [3:0] dly_code_i = '0;
    logic [7:0] drive_o;

    int checks = 0;
    int fails  = 0;
    int yv  [NPIX];
    int sv  [NPIX];
    int shv [NPIX];
    int rv  [NPIX];
    int gv  [NPIX];
    int bv  [NPIX];

    svm_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
        .osd_sel_i(osd_sel_i), .span_a_i(span_a_i), .span_b_i(span_b_i),
        .gain_a_i(gain_a_i), .gain_b_i(gain_b_i), .core_thr_i(core_thr_i),
        .limit_i(limit_i), .dly_code_i(dly_code_i), .drive_o(drive_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic check(string tag, int actual, int expected, int cyc);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, actual, expected);
        end
    endtask

    function automatic int pix(int p, int kind, int ch);
        case (kind)
            1: pix = 120 + ((p * 3 + ch * 5) % 9) - 4;
            3: pix = ((p / 4) % 2 == 1) ? 230 - ch * 7 : 20 + ch * 3;
            default: pix = (p * p * 13 + p * 71 + kind * 29 + ch * 97) % 256;
        endcase
    endfunction

    function automatic int eff_span(int s);
        if (s == 0) return 1;
        if (s > 6) return 6;
        return s;
    endfunction

    function automatic int shp(int d, int gain, int thr, int lim);
        int m, c, sc, l;
        m  = (d < 0) ? -d : d;
        c  = (m > thr) ? m - thr : 0;
        sc = (c * gain) / 32;
        l  = (lim > 127) ? 127 : lim;
        if (sc > l) sc = l;
        return (d < 0) ? 128 - sc : 128 + sc;
    endfunction

    function automatic int sh_at(int i);
        return (i < 0) ? 128 : shv[i];
    endfunction

    function automatic int exp_out(int e, int dly);
        int c, h, k;
        c = (dly < -7) ? -7 : dly;
        h = 7 + c;
        k = h / 2;
        if (h % 2 == 0) return sh_at(e - 3 - k);
        return (sh_at(e - 3 - k) + sh_at(e - 4 - k) + 1) / 2;
    endfunction

    task automatic drive_pix(int p);
        red_i = 8'(rv[p]);
        grn_i = 8'(gv[p]);
        blu_i = 8'(bv[p]);
        osd_sel_i = sv[p][0];
    endtask

    task automatic run_case(string tag, int spa, int spb, int ga, int gb,
                            int thr, int lim, int dly, int kind, int len);
        int n, d, old;
        span_a_i = 3'(spa);  span_b_i = 3'(spb);
        gain_a_i = 8'(ga);   gain_b_i = 8'(gb);
        core_thr_i = 8'(thr); limit_i = 8'(lim);
        dly_code_i = 4'(dly);
        for (int p = 0; p < len + 12; p++) begin
            rv[p] = pix(p, kind, 0);
            gv[p] = pix(p, kind, 1);
            bv[p] = pix(p, kind, 2);
            sv[p] = (kind == 2) ? p % 2 : ((kind == 3) ? (p / 3) % 2 : 0);
            yv[p] = (rv[p] + 2 * gv[p] + bv[p]) / 4;
            n   = eff_span(sv[p] == 1 ? spb : spa);
            old = (p - n >= 0) ? yv[p - n] : 0;
            d   = yv[p] - old;
            shv[p] = shp(d, (sv[p] == 1) ? gb : ga, thr, lim);
        end
        @(negedge clk);
        rst_n = 1'b0;
        red_i = '0; grn_i = '0; blu_i = '0; osd_sel_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive_pix(0);
        for (int e = 0; e < len + 9; e++) begin
            @(posedge clk);
            @(negedge clk);
            check(tag, int'(drive_o), exp_out(e, dly), e);
            drive_pix(e + 1);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", int'(drive_o), 128, 0);
        rst_n = 1'b1;
        red_i = '0; grn_i = '0; blu_i = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 after release", int'(drive_o), 128, 4);
    endtask

    task automatic t_span();
        run_case("R2 span1", 1, 1, 32, 32, 0, 127, 1, 0, 30);
        run_case("R2 span4", 4, 4, 16, 16, 0, 127, 1, 0, 30);
        run_case("R2 span6", 6, 6, 20, 20, 0, 127, 1, 3, 30);
    endtask

    task automatic t_span_clamp();
        run_case("R2 span0", 0, 0, 24, 24, 0, 127, 1, 0, 30);
        run_case("R2 span7", 7, 7, 24, 24, 0, 127, 1, 3, 30);
    endtask

    task automatic t_set_switch();
        run_case("R3 alt", 1, 5, 32, 96, 0, 127, 1, 2, 40);
        run_case("R3 runs", 2, 6, 8, 64, 0, 127, 1, 3, 40);
    endtask

    task automatic t_coring();
        run_case("R4 small", 1, 1, 64, 64, 3, 127, 1, 1, 30);
        run_case("R4 large", 1, 1, 32, 32, 40, 127, 1, 0, 30);
    endtask

    task automatic t_gain();
        run_case("R5 g2.5", 1, 1, 80, 80, 0, 127, 1, 3, 30);
        run_case("R5 gsmall", 3, 3, 7, 7, 0, 127, 1, 0, 30);
    endtask

    task automatic t_limit();
        run_case("R6 lim40", 1, 1, 255, 255, 0, 40, 1, 0, 30);
        run_case("R6 lim200", 2, 2, 255, 255, 0, 200, 1, 3, 30);
    endtask

    task automatic t_delay();
        run_case("R7 dly-7", 1, 1, 32, 32, 0, 127, -7, 0, 24);
        run_case("R7 dly0", 1, 1, 32, 32, 0, 127, 0, 0, 24);
        run_case("R7 dly7", 1, 1, 32, 32, 0, 127, 7, 0, 24);
        run_case("R7 dly6", 2, 2, 32, 32, 0, 127, 6, 3, 24);
        run_case("R7 dly-3", 2, 2, 32, 32, 0, 127, -3, 3, 24);
    endtask

    task automatic t_delay_sat();
        run_case("R8 dly-8", 1, 1, 32, 32, 0, 127, -8, 0, 24);
    endtask

    initial begin
        t_reset();
        t_span();
        t_span_clamp();
        t_set_switch();
        t_coring();
        t_gain();
        t_limit();
        t_delay();
        t_delay_sat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule